// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a direct-mapped, tagged table that the fetch stage reads with the current fetch address. It answers in the same cycle. When the address matches a valid entry and that entry's two-bit direction counter leans toward taken, the block returns the stored destination as the next fetch address, so fetch can redirect in the following cycle with no decode step. In every other case it returns the sequential address, fetch PC plus the instruction size.

A separate update port, driven once a branch has resolved, keeps the table current. A taken branch that misses claims the slot its address maps to and evicts whatever was there. A branch that hits moves its counter one step toward the outcome and has its destination rewritten if it went somewhere other than the stored one. A not-taken branch that misses leaves the table unchanged.

Top module: `fetch_target_buf`

## Requirements
- R1: After reset every entry is invalid: `hit_o` and `taken_o` are 0 and `next_pc_o` equals `fetch_pc_i + 4` for any fetch address.
- R2: The slot is selected by `fetch_pc_i[ALIGN_W+IDX_W-1:ALIGN_W]`, and the bits above it form the tag. An address that shares the slot of a stored branch but differs in the tag misses, and so does an address that maps to another slot.
- R3: When the lookup hits and the entry's counter is 2 or 3, `taken_o` is 1 and `next_pc_o` is the stored destination.
- R4: On a miss, or on a hit whose counter is 0 or 1, `taken_o` is 0 and `next_pc_o` is `fetch_pc_i + 4`.
- R5: A taken update that misses installs an entry with the update's tag and destination and counter 2 (weakly taken), and it replaces any other branch at that slot.
- R6: A not-taken update that misses changes no entry.
- R7: On an update that hits, the counter (0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken) goes up by one when taken and down by one when not taken, and holds at 3 and at 0.
- R8: A taken update that hits with a different destination overwrites the stored destination. A not-taken update that hits leaves the destination unchanged.
- R9: An update is written at the clock edge that samples it. A lookup of the same address in that cycle still sees the old contents.
- R10: `hit_o` reports a valid tag match whatever the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Current fetch address |
| hit_o | output | 1 | Valid entry with a matching tag |
| taken_o | output | 1 | Redirect to the stored destination |
| next_pc_o | output | PC_W | Address to fetch next |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | PC_W-ALIGN_W | Word address of the resolved branch (alignment bits dropped) |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | PC_W | Resolved destination |

## Verification
The bench builds the block with 32-bit addresses and IDX_W=3, so there are eight slots. With eight slots, two branches 32 bytes apart collide, which exercises eviction and tag mismatch, and a full sweep installing one branch per slot stays short. The counter is driven into both saturation limits, each with a follow-up update, so a wrapping counter gives a different redirect decision. One cycle presents an update and a lookup of the same address together to pin down when the write takes effect.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } dir_ctr_e;

  localparam dir_ctr_e CTR_ALLOC = CTR_WT;

  function automatic dir_ctr_e ctr_step(dir_ctr_e cur, logic taken);
    dir_ctr_e nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : dir_ctr_e'(cur + 2'd1);
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : dir_ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(dir_ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/ftb_pc_split.sv
module ftb_pc_split #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 4,
  localparam int TAG_W  = PC_W - ALIGN_W - IDX_W
) (
  input  logic [PC_W-1:ALIGN_W] word_addr_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic [TAG_W-1:0]      tag_o
);
  assign idx_o = word_addr_i[ALIGN_W+IDX_W-1:ALIGN_W];
  assign tag_o = word_addr_i[PC_W-1:ALIGN_W+IDX_W];
endmodule

// File: rtl/ftb_table.sv
module ftb_table
  import ftb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // fetch read port
  input  logic [IDX_W-1:0] f_idx_i,
  output logic             f_vld_o,
  output logic [TAG_W-1:0] f_tag_o,
  output logic [PC_W-1:0]  f_tgt_o,
  output dir_ctr_e         f_ctr_o,
  // update read port
  input  logic [IDX_W-1:0] u_idx_i,
  output logic             u_vld_o,
  output logic [TAG_W-1:0] u_tag_o,
  output logic [PC_W-1:0]  u_tgt_o,
  output dir_ctr_e         u_ctr_o,
  // write port
  input  logic             wr_alloc_i,
  input  logic             wr_ctr_en_i,
  input  logic             wr_tgt_en_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  dir_ctr_e         wr_ctr_i
);

  logic [DEPTH-1:0]            vld_all;
  logic [DEPTH-1:0][TAG_W-1:0] tag_all;
  logic [DEPTH-1:0][PC_W-1:0]  tgt_all;
  logic [DEPTH-1:0][1:0]       ctr_all;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             sel;
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;
    logic [PC_W-1:0]  tgt_q;
    dir_ctr_e         ctr_q;

    assign sel = (u_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        tgt_q <= '0;
        ctr_q <= CTR_SNT;
      end else if (sel) begin
        if (wr_alloc_i) begin
          vld_q <= 1'b1;
          tag_q <= wr_tag_i;
          tgt_q <= wr_tgt_i;
          ctr_q <= wr_ctr_i;
        end else begin
          if (wr_ctr_en_i) ctr_q <= wr_ctr_i;
          if (wr_tgt_en_i) tgt_q <= wr_tgt_i;
        end
      end
    end

    assign vld_all[e] = vld_q;
    assign tag_all[e] = tag_q;
    assign tgt_all[e] = tgt_q;
    assign ctr_all[e] = ctr_q;
  end

  assign f_vld_o = vld_all[f_idx_i];
  assign f_tag_o = tag_all[f_idx_i];
  assign f_tgt_o = tgt_all[f_idx_i];
  assign f_ctr_o = dir_ctr_e'(ctr_all[f_idx_i]);

  assign u_vld_o = vld_all[u_idx_i];
  assign u_tag_o = tag_all[u_idx_i];
  assign u_tgt_o = tgt_all[u_idx_i];
  assign u_ctr_o = dir_ctr_e'(ctr_all[u_idx_i]);

endmodule

// File: rtl/ftb_upd_ctrl.sv
module ftb_upd_ctrl
  import ftb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 26
) (
  input  logic             upd_valid_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic             ent_vld_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  dir_ctr_e         ent_ctr_i,
  output logic             wr_alloc_o,
  output logic             wr_ctr_en_o,
  output logic             wr_tgt_en_o,
  output dir_ctr_e         wr_ctr_o
);
  logic ent_hit;

  assign ent_hit     = ent_vld_i && (ent_tag_i == upd_tag_i);
  assign wr_alloc_o  = upd_valid_i && upd_taken_i && !ent_hit;
  assign wr_ctr_en_o = upd_valid_i && ent_hit;
  // not-taken outcomes never touch the destination
  assign wr_tgt_en_o = upd_valid_i && ent_hit && upd_taken_i && (ent_tgt_i != upd_target_i);
  assign wr_ctr_o    = wr_alloc_o ? CTR_ALLOC : ctr_step(ent_ctr_i, upd_taken_i);
endmodule

// File: rtl/ftb_lookup.sv
module ftb_lookup
  import ftb_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int TAG_W       = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             ent_vld_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  dir_ctr_e         ent_ctr_i,
  output logic             hit_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);
  assign hit_o     = ent_vld_i && (ent_tag_i == req_tag_i);
  assign taken_o   = hit_o && ctr_says_taken(ent_ctr_i);
  assign next_pc_o = taken_o ? ent_tgt_i : pc_i + PC_W'(INSTR_BYTES);
endmodule

// File: rtl/fetch_target_buf.sv
module fetch_target_buf
  import ftb_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  parameter int IDX_W       = 4,
  localparam int ALIGN_W    = $clog2(INSTR_BYTES),
  localparam int TAG_W      = PC_W - ALIGN_W - IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PC_W-1:0]       fetch_pc_i,
  output logic                  hit_o,
  output logic                  taken_o,
  output logic [PC_W-1:0]       next_pc_o,
  input  logic                  upd_valid_i,
  input  logic [PC_W-1:ALIGN_W] upd_pc_i,
  input  logic                  upd_taken_i,
  input  logic [PC_W-1:0]       upd_target_i
);

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             f_vld, u_vld;
  logic [TAG_W-1:0] f_ent_tag, u_ent_tag;
  logic [PC_W-1:0]  f_ent_tgt, u_ent_tgt;
  dir_ctr_e         f_ent_ctr, u_ent_ctr;
  logic             wr_alloc, wr_ctr_en, wr_tgt_en;
  dir_ctr_e         wr_ctr;

  ftb_pc_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_split_f (
    .word_addr_i (fetch_pc_i[PC_W-1:ALIGN_W]),
    .idx_o       (f_idx),
    .tag_o       (f_tag)
  );

  ftb_pc_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_split_u (
    .word_addr_i (upd_pc_i),
    .idx_o       (u_idx),
    .tag_o       (u_tag)
  );

  ftb_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .f_idx_i     (f_idx),
    .f_vld_o     (f_vld),
    .f_tag_o     (f_ent_tag),
    .f_tgt_o     (f_ent_tgt),
    .f_ctr_o     (f_ent_ctr),
    .u_idx_i     (u_idx),
    .u_vld_o     (u_vld),
    .u_tag_o     (u_ent_tag),
    .u_tgt_o     (u_ent_tgt),
    .u_ctr_o     (u_ent_ctr),
    .wr_alloc_i  (wr_alloc),
    .wr_ctr_en_i (wr_ctr_en),
    .wr_tgt_en_i (wr_tgt_en),
    .wr_tag_i    (u_tag),
    .wr_tgt_i    (upd_target_i),
    .wr_ctr_i    (wr_ctr)
  );

  ftb_upd_ctrl #(.PC_W(PC_W), .TAG_W(TAG_W)) u_upd (
    .upd_valid_i  (upd_valid_i),
    .upd_taken_i  (upd_taken_i),
    .upd_target_i (upd_target_i),
    .upd_tag_i    (u_tag),
    .ent_vld_i    (u_vld),
    .ent_tag_i    (u_ent_tag),
    .ent_tgt_i    (u_ent_tgt),
    .ent_ctr_i    (u_ent_ctr),
    .wr_alloc_o   (wr_alloc),
    .wr_ctr_en_o  (wr_ctr_en),
    .wr_tgt_en_o  (wr_tgt_en),
    .wr_ctr_o     (wr_ctr)
  );

  ftb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W), .INSTR_BYTES(INSTR_BYTES)) u_look (
    .pc_i      (fetch_pc_i),
    .req_tag_i (f_tag),
    .ent_vld_i (f_vld),
    .ent_tag_i (f_ent_tag),
    .ent_tgt_i (f_ent_tgt),
    .ent_ctr_i (f_ent_ctr),
    .hit_o     (hit_o),
    .taken_o   (taken_o),
    .next_pc_o (next_pc_o)
  );

endmodule

// File: rtl/fetch_target_buf_chk.sv
module fetch_target_buf_chk #(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4,
  localparam int ALIGN_W    = $clog2(INSTR_BYTES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [PC_W-1:0]       fetch_pc_i,
  input logic                  hit_o,
  input logic                  taken_o,
  input logic [PC_W-1:0]       next_pc_o,
  input logic                  upd_valid_i,
  input logic [PC_W-1:ALIGN_W] upd_pc_i,
  input logic                  upd_taken_i,
  input logic [PC_W-1:0]       upd_target_i
);
  logic same_pc;
  assign same_pc = (fetch_pc_i[PC_W-1:ALIGN_W] == upd_pc_i);

  // R1: table cleared while reset is held
  a_r1_reset_empty: assert property (@(posedge clk_i) !rst_ni |-> !hit_o && !taken_o);

  // R3: redirect only on a hit
  a_r3_taken_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> hit_o);

  // R4: no redirect means sequential next address
  a_r4_seq_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> next_pc_o == fetch_pc_i + PC_W'(INSTR_BYTES));

  // R5: taken miss installs a taken-predicting entry
  a_r5_alloc_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && same_pc && !hit_o) |=>
      (!$stable(fetch_pc_i) || (hit_o && taken_o && next_pc_o == $past(upd_target_i))));

  // R6: not-taken miss installs nothing
  a_r6_no_alloc_nt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && same_pc && !hit_o) |=>
      (!$stable(fetch_pc_i) || !hit_o));

  // R7: strongly/weakly taken stays taken after another taken outcome
  a_r7_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && same_pc && taken_o) |=>
      (!$stable(fetch_pc_i) || taken_o));

  // R8: after a taken hit, any redirect goes to the resolved destination
  a_r8_target_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && same_pc && hit_o) |=>
      (!$stable(fetch_pc_i) || !taken_o || next_pc_o == $past(upd_target_i)));

  // R9: contents change only through the update port
  a_r9_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (!$stable(fetch_pc_i) || ($stable(hit_o) && $stable(next_pc_o))));

endmodule

bind fetch_target_buf fetch_target_buf_chk #(
  .PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_pc_i   (fetch_pc_i),
  .hit_o        (hit_o),
  .taken_o      (taken_o),
  .next_pc_o    (next_pc_o),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i),
  .upd_target_i (upd_target_i)
);

// File: tb/fetch_target_buf_test.sv
module fetch_target_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int IDX_W = 3;

  typedef struct {
    logic [31:0] pc;
    logic        hit;
    logic        tkn;
    logic [31:0] nxt;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, taken;
  logic [31:0] next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_target_buf #(.PC_W(PC_W), .INSTR_BYTES(4), .IDX_W(IDX_W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .fetch_pc_i   (fetch_pc),
    .hit_o        (hit),
    .taken_o      (taken),
    .next_pc_o    (next_pc),
    .upd_valid_i  (upd_valid),
    .upd_pc_i     (upd_pc[31:2]),
    .upd_taken_i  (upd_taken),
    .upd_target_i (upd_target)
  );

  task automatic look(input logic [31:0] pc, input logic h, input logic t,
                      input logic [31:0] n, input string req);
    exp_t e;
    @(negedge clk);
    fetch_pc = pc;
    e.pc = pc; e.hit = h; e.tkn = t; e.nxt = n; e.req = req;
    q.push_back(e);
  endtask

  task automatic upd(input logic [31:0] pc, input logic t, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tgt;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  // monitor: compare in mid-cycle, after the driver has settled inputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (hit !== e.hit || taken !== e.tkn || next_pc !== e.nxt) begin
          n_bad++;
          $display("FAIL %s pc=%h: got hit=%b taken=%b next=%h, exp hit=%b taken=%b next=%h",
                   e.req, e.pc, hit, taken, next_pc, e.hit, e.tkn, e.nxt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    look(32'h100, 0, 0, 32'h104, "R1");
    look(32'h11C, 0, 0, 32'h120, "R1");

    // R6 not-taken miss installs nothing
    upd(32'h100, 0, 32'h400);
    look(32'h100, 0, 0, 32'h104, "R6");

    // R5/R3 taken miss allocates weakly taken
    upd(32'h100, 1, 32'h400);
    look(32'h100, 1, 1, 32'h400, "R5");
    look(32'h100, 1, 1, 32'h400, "R3");

    // R2 alias in tag, different slot
    look(32'h120, 0, 0, 32'h124, "R2");
    look(32'h104, 0, 0, 32'h108, "R2");

    // R10/R4 hit with counter 1
    upd(32'h100, 0, 32'h400);
    look(32'h100, 1, 0, 32'h104, "R10");

    // R7 low saturation: 1->0->0->1 stays not taken, then 2
    upd(32'h100, 0, 32'h400);
    upd(32'h100, 0, 32'h400);
    upd(32'h100, 1, 32'h400);
    look(32'h100, 1, 0, 32'h104, "R7");
    upd(32'h100, 1, 32'h400);
    look(32'h100, 1, 1, 32'h400, "R8");  // not-taken hits kept the destination

    // R8 wrong destination overwritten
    upd(32'h100, 1, 32'h800);
    look(32'h100, 1, 1, 32'h800, "R8");

    // R7 high saturation: 3,3,3 then down to 2 still taken
    upd(32'h100, 1, 32'h800);
    upd(32'h100, 1, 32'h800);
    upd(32'h100, 0, 32'h800);
    look(32'h100, 1, 1, 32'h800, "R7");

    // R5 replacement at shared slot
    upd(32'h120, 1, 32'h900);
    look(32'h120, 1, 1, 32'h900, "R5");
    look(32'h100, 0, 0, 32'h104, "R5");

    // R9 same-cycle lookup sees old contents
    @(negedge clk);
    fetch_pc = 32'h108;
    upd_valid = 1'b1; upd_pc = 32'h108; upd_taken = 1'b1; upd_target = 32'hA00;
    begin
      exp_t e;
      e.pc = 32'h108; e.hit = 0; e.tkn = 0; e.nxt = 32'h10C; e.req = "R9";
      q.push_back(e);
    end
    @(posedge clk);
    #1 upd_valid = 1'b0;
    look(32'h108, 1, 1, 32'hA00, "R9");

    // R2/R3 sweep of every slot
    for (int i = 0; i < (1 << IDX_W); i++)
      upd(32'h200 + 32'(i * 4), 1, 32'h3000 + 32'(i * 16));
    for (int i = 0; i < (1 << IDX_W); i++)
      look(32'h200 + 32'(i * 4), 1, 1, 32'h3000 + 32'(i * 16), "R2");
    look(32'h108, 0, 0, 32'h10C, "R5");

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule